// File: doc/BRIEF.md
# Set/Clear/Toggle Register Bank

A bank of 32-bit control registers on a simple synchronous bus. Each logical register takes four consecutive words. The first word gives plain read and write access. The other three treat the write data as a mask: each bit that is 1 sets, clears or inverts the matching register bit. Bits written as 0 leave their register bits alone. Software can therefore change single bits without a read-modify-write sequence.

Register 0 holds two control bits. Bit 31 is a soft reset and bit 30 is a clock gate. Together they control a small modelled core, a free-running counter. While soft reset is high, the other registers and the counter are forced to zero. A fixed number of cycles after soft reset goes high, the block sets its own clock-gate bit, so software can poll for that bit to confirm the reset has taken effect. While the gate is high, the counter holds its value.

Top module: `sct_reg_bank`

## Requirements
- R1: The byte address splits into a register index in bits [ADDR_W-1:4] and an alias code in bits [3:2]. Code 0 (offset 0x0) is plain access, and a plain write stores wdata_i unchanged.
- R2: A write with alias code 1 (offset 0x4) sets to 1 every register bit whose wdata_i bit is 1. All other bits keep their value.
- R3: A write with alias code 2 (offset 0x8) clears to 0 every register bit whose wdata_i bit is 1. All other bits keep their value.
- R4: A write with alias code 3 (offset 0xC) inverts every register bit whose wdata_i bit is 1. All other bits keep their value.
- R5: A read at any of the four aliases of a register returns its current value on rdata_o in the cycle after rd_en_i is sampled. rdata_o holds its value when no read is made.
- R6: After hardware reset, register 0 reads 0xC000_0000 (soft reset and gate both set), every other register reads 0, and core_cnt_o is 0.
- R7: While register 0 bit 31 is 1, the following are forced to 0 at every clock and bus writes to them have no effect: register 0 bits [29:0], all other registers, and core_cnt_o.
- R8: While bits 31 and 30 of register 0 are both 0, core_cnt_o increases by 1 each cycle. While bit 31 is 0 and bit 30 is 1, core_cnt_o holds its value.
- R9: When bit 31 becomes 1 while bit 30 is 0, bit 30 reads 1 exactly GATE_DELAY (4) cycles after bit 31 first reads 1. This happens once per soft-reset episode, so a later software clear of bit 30 stays in effect while bit 31 remains 1.
- R10: A bus write to register 0 in the cycle the self-set would fire takes priority, and the self-set is dropped. Clearing bit 31 before the delay ends cancels the self-set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address: register index and alias code |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data or bit mask |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| core_cnt_o | output | CNT_W | Modelled core counter value |

## Verification
The assertions assume that the bus never asserts wr_en_i and rd_en_i in the same cycle. They also assume the address always names an existing register, which a power-of-two NUM_REGS guarantees. The alias properties are stated for register 1 outside soft reset, where the soft-reset clearing cannot interfere. The stimulus issues one bus operation per cycle and never combines a read with a write. Every soft-reset episode starts from a known register 0 value, so the self-set timing can be counted from the write that raises bit 31.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int DATA_W   = 32;
  localparam int SRST_BIT = 31;
  localparam int GATE_BIT = 30;
  localparam logic [DATA_W-1:0] REG0_RST  = 32'hC000_0000;
  localparam logic [DATA_W-1:0] GATE_MASK = 32'h4000_0000;
  localparam logic [DATA_W-1:0] LOW_MASK  = 32'h3FFF_FFFF;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] apply_op(alias_op_e op,
                                                 logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] wd);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/sct_addr_dec.sv
module sct_addr_dec
  import sct_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  output logic [IDX_W-1:0]    idx_o,
  output alias_op_e           op_o,
  output logic [NUM_REGS-1:0] wr_sel_o
);
  assign idx_o = addr_i[ADDR_W-1:4];
  assign op_o  = alias_op_e'(addr_i[3:2]);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign wr_sel_o[r] = wr_en_i && (idx_o == IDX_W'(r));
  end
endmodule

// File: rtl/sct_reg_slice.sv
module sct_reg_slice
  import sct_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] clr_mask_i,  // forced low, beats bus
  input  logic [DATA_W-1:0] set_mask_i,  // forced high
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] bus_d, nxt;

  always_comb begin
    bus_d = wr_i ? apply_op(op_i, q_o, wdata_i) : q_o;
    nxt   = (bus_d & ~clr_mask_i) | set_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_VAL;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/sct_srst_ctrl.sv
module sct_srst_ctrl #(
  parameter int GATE_DELAY = 4,
  localparam int DLY_W = $clog2(GATE_DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic reg0_wr_i,
  output logic self_set_o
);
  logic [DLY_W-1:0] dly_q;

  // saturating count: one self-set per soft-reset episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           dly_q <= DLY_W'(GATE_DELAY);
    else if (!srst_i)                      dly_q <= '0;
    else if (dly_q != DLY_W'(GATE_DELAY))  dly_q <= dly_q + 1'b1;
  end

  assign self_set_o = srst_i && !reg0_wr_i && (dly_q == DLY_W'(GATE_DELAY - 1));
endmodule

// File: rtl/sct_core_model.sv
module sct_core_model #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (srst_i)  cnt_o <= '0;
    else if (!gate_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
  import sct_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int GATE_DELAY = 4,
  parameter int CNT_W      = 16,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  core_cnt_o
);
  logic [IDX_W-1:0]           idx;
  alias_op_e                  op;
  logic [NUM_REGS-1:0]        wr_sel;
  logic [DATA_W-1:0]          reg_q [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic                       srst, gate, self_set;

  sct_addr_dec #(.NUM_REGS(NUM_REGS)) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .idx_o    (idx),
    .op_o     (op),
    .wr_sel_o (wr_sel)
  );

  assign srst = reg_q[0][SRST_BIT];
  assign gate = reg_q[0][GATE_BIT];

  sct_srst_ctrl #(.GATE_DELAY(GATE_DELAY)) u_srst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst),
    .reg0_wr_i  (wr_sel[0]),
    .self_set_o (self_set)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V   = (r == 0) ? REG0_RST : '0;
    localparam logic [DATA_W-1:0] SRST_CM = (r == 0) ? LOW_MASK : '1;
    logic [DATA_W-1:0] clr_mask, set_mask;

    assign clr_mask = srst ? SRST_CM : '0;
    if (r == 0) begin : g_ctl
      assign set_mask = self_set ? GATE_MASK : '0;
    end else begin : g_dat
      assign set_mask = '0;
    end

    sct_reg_slice #(.RESET_VAL(RST_V)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_sel[r]),
      .op_i       (op),
      .wdata_i    (wdata_i),
      .clr_mask_i (clr_mask),
      .set_mask_i (set_mask),
      .q_o        (reg_q[r])
    );
    assign regs_flat[r*DATA_W +: DATA_W] = reg_q[r];
  end

  sct_core_model #(.CNT_W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .gate_i (gate),
    .cnt_o  (core_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= reg_q[idx];
  end
endmodule

// File: rtl/sct_reg_bank_chk.sv
module sct_reg_bank_chk #(
  parameter int NUM_REGS = 4,
  parameter int CNT_W    = 16,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ADDR_W = IDX_W + 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        addr_i,
  input logic                     wr_en_i,
  input logic [31:0]              wdata_i,
  input logic                     rd_en_i,
  input logic [31:0]              rdata_o,
  input logic [CNT_W-1:0]         core_cnt_o,
  input logic [NUM_REGS*32-1:0]   regs_flat
);
  logic [31:0]      reg0, reg1, sel_val;
  logic [IDX_W-1:0] a_idx;
  logic [1:0]       a_op;
  logic             wr_r1;

  assign reg0    = regs_flat[31:0];
  assign reg1    = regs_flat[63:32];
  assign a_idx   = addr_i[ADDR_W-1:4];
  assign a_op    = addr_i[3:2];
  assign sel_val = regs_flat[a_idx*32 +: 32];
  assign wr_r1   = wr_en_i && (a_idx == IDX_W'(1)) && !reg0[31];

  AST_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r1 && a_op == 2'd1 |=> reg1 == $past(reg1 | wdata_i)); // R2
  AST_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r1 && a_op == 2'd2 |=> reg1 == $past(reg1 & ~wdata_i)); // R3
  AST_TOG_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r1 && a_op == 2'd3 |=> reg1 == $past(reg1 ^ wdata_i)); // R4
  AST_READ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i |=> rdata_o == $past(sel_val)); // R5
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R5
  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg0[31] |=> reg1 == 32'h0 && reg0[29:0] == 30'h0 && core_cnt_o == '0); // R7
  AST_GATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg0[31] && reg0[30] |=> $stable(core_cnt_o)); // R8
  AST_CORE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg0[31] && !reg0[30] |=> core_cnt_o == CNT_W'($past(core_cnt_o) + 1'b1)); // R8
endmodule

bind sct_reg_bank sct_reg_bank_chk #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rd_en_i    (rd_en_i),
  .rdata_o    (rdata_o),
  .core_cnt_o (core_cnt_o),
  .regs_flat  (regs_flat)
);

// File: tb/sct_reg_bank_bench.sv
module sct_reg_bank_bench;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [CNT_W-1:0] cnt;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;
  logic [CNT_W-1:0] c0;

  always #2.5 clk = ~clk;

  sct_reg_bank u_sct_reg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .core_cnt_o(cnt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare one cycle after each sampled read
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("R5 unexpected read", rdata, 32'hx);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    chk("R6 core count", 32'(cnt), 32'h0);
    chk("R6 rdata", rdata, 32'h0);
    rd(6'h00, 32'hC000_0000, "R6 reg0");
    rd(6'h10, 32'h0, "R6 reg1");
    // release soft reset and gate
    wr(6'h08, 32'hC000_0000);
    rd(6'h00, 32'h0, "R3 reg0 release");
    // plain and alias access on reg1
    wr(6'h10, 32'hA5A5_0F0F);
    rd(6'h10, 32'hA5A5_0F0F, "R1 plain");
    rd(6'h14, 32'hA5A5_0F0F, "R5 via set alias");
    rd(6'h18, 32'hA5A5_0F0F, "R5 via clr alias");
    rd(6'h1C, 32'hA5A5_0F0F, "R5 via tog alias");
    idle(2);
    chk("R5 rdata holds", rdata, 32'hA5A5_0F0F);
    wr(6'h14, 32'h0000_F0F0);
    rd(6'h10, 32'hA5A5_FFFF, "R2 set");
    wr(6'h18, 32'hA000_000F);
    rd(6'h10, 32'h05A5_FFF0, "R3 clr");
    wr(6'h1C, 32'hFFFF_0000);
    rd(6'h10, 32'hFA5A_FFF0, "R4 tog");
    wr(6'h20, 32'h1234_5678);
    rd(6'h20, 32'h1234_5678, "R1 reg2");
    rd(6'h10, 32'hFA5A_FFF0, "R1 reg1 untouched");
    // gate holds the counter, clearing it resumes counting
    wr(6'h04, 32'h4000_0000);
    c0 = cnt;
    idle(5);
    chk("R8 gated hold", 32'(cnt), 32'(c0));
    wr(6'h08, 32'h4000_0000);
    c0 = cnt;
    idle(10);
    chk("R8 running", 32'(cnt), 32'(c0 + 16'd10));
    // soft reset: clears and self-gates after 4 cycles
    wr(6'h00, 32'h0000_0003);
    rd(6'h00, 32'h0000_0003, "R1 reg0 low bits");
    wr(6'h04, 32'h8000_0000);
    rd(6'h00, 32'h8000_0003, "R9 srst cycle1");
    rd(6'h00, 32'h8000_0000, "R7 low bits cleared");
    rd(6'h00, 32'h8000_0000, "R9 srst cycle3");
    rd(6'h00, 32'h8000_0000, "R9 no gate at cycle4");
    rd(6'h00, 32'hC000_0000, "R9 gate at delay");
    chk("R7 core cleared", 32'(cnt), 32'h0);
    rd(6'h10, 32'h0, "R7 reg1 cleared");
    rd(6'h20, 32'h0, "R7 reg2 cleared");
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0, "R7 write ignored");
    wr(6'h08, 32'h4000_0000);
    idle(6);
    rd(6'h00, 32'h8000_0000, "R9 gate stays cleared");
    // bus write to reg0 in the firing cycle wins
    wr(6'h08, 32'hC000_0000);
    wr(6'h04, 32'h8000_0000);
    idle(3);
    wr(6'h04, 32'h0000_0010);
    rd(6'h00, 32'h8000_0000, "R10 bus wins");
    idle(4);
    rd(6'h00, 32'h8000_0000, "R10 no late gate");
    // clearing soft reset early cancels the self-set
    wr(6'h08, 32'h8000_0000);
    wr(6'h04, 32'h8000_0000);
    idle(2);
    wr(6'h08, 32'h8000_0000);
    idle(4);
    rd(6'h00, 32'h0, "R10 cancelled");
    c0 = cnt;
    idle(3);
    chk("R8 runs after cancel", 32'(cnt), 32'(c0 + 16'd3));
    idle(2);
    chk("R5 queue drained", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule